// File: doc/BRIEF.md
# Video-Interleaved DRAM Address Multiplexer

This block shares one bank of 64K x 1 dynamic RAMs between a video fetch engine and a CPU. An external four-phase slot counter divides each memory slot into a CPU half and a video half. In each half the block drives a multiplexed DRAM address with active-low row and column strobes. The low address byte goes out while the row strobe falls, and the high byte follows with the column strobe. Because of this ordering, any run of consecutive byte addresses walks through the DRAM rows, so video fetch or linear CPU code refreshes the array with no refresh counter of its own.

The CPU strobe that normally announces a refresh cycle is ignored. The half of the slot that lines up with CPU T-states 3 and 4 belongs to video alone, and a CPU request made there is stalled through the wait output. A CPU read aimed at ROM still puts its row on the bus and pulses the row strobe, but the column strobe stays high, so such reads refresh rows too. A built-in monitor keeps an age counter for every one of the 128 rows and raises a sticky error flag if any row goes a programmable number of clocks without a row strobe.

Top module: `vram_addr_mux`

## Requirements
- R1: While reset is held and at the first sample after it, ras_n and cas_n are 1, dram_a is 0 and refresh_err is 0.
- R2: The clock edge that samples slot_ph = 2 (video row) drives vid_addr[7:0] onto dram_a with ras_n = 0 and cas_n = 1, whatever the CPU inputs are.
- R3: The edge that samples slot_ph = 3 (video column) drives the vid_addr[15:8] value latched at phase 2, with ras_n = 0 and cas_n = 0. The CPU address never appears in phases 2 and 3.
- R4: When cpu_mreq = 1 at the edge that samples slot_ph = 0, dram_a becomes cpu_addr[7:0] with ras_n = 0 and cas_n = 1. At the following phase-1 edge, dram_a becomes the latched cpu_addr[15:8] with ras_n = 0 and cas_n = 0.
- R5: If cpu_rom = 1 at the phase-0 edge of an accepted request, the phase-1 edge keeps ras_n = 0 but leaves cas_n = 1.
- R6: cpu_wait is 1 whenever cpu_mreq = 1 and slot_ph is 2 or 3, or slot_ph is 1 with no request accepted at the preceding phase 0. It is 0 while slot_ph = 0.
- R7: Phases 0 and 1 without an accepted CPU request leave ras_n = 1 and cas_n = 1.
- R8: cpu_rfsh has no effect: idle CPU phases with cpu_rfsh = 1 keep both strobes high, and the refresh monitor still flags starvation.
- R9: A row is the value of dram_a bits 6:0 at a row strobe. refresh_err rises once any row has gone about REFRESH_LIMIT clocks since reset or since its last strobe, and it stays at 1 until reset.
- R10: Strobing 128 consecutive addresses, by video or by CPU ROM reads, within each REFRESH_LIMIT window keeps refresh_err at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_ph | input | 2 | Slot phase: 0 CPU row, 1 CPU column, 2 video row, 3 video column |
| cpu_addr | input | 16 | CPU byte address |
| cpu_mreq | input | 1 | CPU memory request |
| cpu_rom | input | 1 | Current CPU read targets ROM |
| cpu_rfsh | input | 1 | CPU refresh strobe, ignored |
| vid_addr | input | 16 | Video fetch byte address |
| dram_a | output | 8 | Multiplexed DRAM address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| cpu_wait | output | 1 | Stall request to the CPU |
| refresh_err | output | 1 | Sticky row-starvation flag |

## Verification
The bench builds the block with 128 rows and REFRESH_LIMIT = 600 clocks in place of the two-millisecond default. A full 128-row sweep at one row strobe per four-clock slot takes 512 clocks, which fits inside that window. A single row held on the bus starves the other rows past the limit in a few hundred cycles. With these values both the refresh-kept-alive case and the starvation case, including the sticky flag, can be reached in a short run.

// File: rtl/vram_addr_mux.sv
module vram_addr_mux #(
  parameter int ADDR_W        = 16,
  parameter int ROWS          = 128,
  parameter int REFRESH_LIMIT = 32000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          slot_ph,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic                cpu_mreq,
  input  logic                cpu_rom,
  input  logic                cpu_rfsh,
  input  logic [ADDR_W-1:0]   vid_addr,
  output logic [ADDR_W/2-1:0] dram_a,
  output logic                ras_n,
  output logic                cas_n,
  output logic                cpu_wait,
  output logic                refresh_err
);
  localparam int HALF  = ADDR_W / 2;
  localparam int ROW_W = $clog2(ROWS);
  localparam int AGE_W = $clog2(REFRESH_LIMIT + 1);
  localparam logic [1:0] PH_CPU_ROW = 2'd0;
  localparam logic [1:0] PH_CPU_COL = 2'd1;
  localparam logic [1:0] PH_VID_ROW = 2'd2;
  localparam logic [1:0] PH_VID_COL = 2'd3;
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(REFRESH_LIMIT);

  logic [HALF-1:0]  vid_hi, cpu_hi;
  logic             cpu_act, rom_q;
  logic             row_go;
  logic [ROW_W-1:0] row_sel;
  logic [ROWS-1:0]  row_stale;

  wire unused_rfsh = cpu_rfsh;

  assign cpu_wait = cpu_mreq &&
                    !(slot_ph == PH_CPU_ROW || (slot_ph == PH_CPU_COL && cpu_act));

  assign row_go  = (slot_ph == PH_VID_ROW) || (slot_ph == PH_CPU_ROW && cpu_mreq);
  assign row_sel = (slot_ph == PH_VID_ROW) ? vid_addr[ROW_W-1:0] : cpu_addr[ROW_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dram_a  <= '0;
      ras_n   <= 1'b1;
      cas_n   <= 1'b1;
      vid_hi  <= '0;
      cpu_hi  <= '0;
      cpu_act <= 1'b0;
      rom_q   <= 1'b0;
    end else begin
      case (slot_ph)
        PH_CPU_ROW: begin
          cas_n   <= 1'b1;
          cpu_act <= cpu_mreq;
          if (cpu_mreq) begin
            dram_a <= cpu_addr[HALF-1:0];
            cpu_hi <= cpu_addr[ADDR_W-1:HALF];
            rom_q  <= cpu_rom;
            ras_n  <= 1'b0;
          end else begin
            ras_n  <= 1'b1;
          end
        end
        PH_CPU_COL: begin
          cpu_act <= 1'b0;
          if (cpu_act) begin
            dram_a <= cpu_hi;
            ras_n  <= 1'b0;
            cas_n  <= rom_q;
          end else begin
            ras_n  <= 1'b1;
            cas_n  <= 1'b1;
          end
        end
        PH_VID_ROW: begin
          dram_a  <= vid_addr[HALF-1:0];
          vid_hi  <= vid_addr[ADDR_W-1:HALF];
          ras_n   <= 1'b0;
          cas_n   <= 1'b1;
          cpu_act <= 1'b0;
        end
        default: begin
          dram_a  <= vid_hi;
          ras_n   <= 1'b0;
          cas_n   <= 1'b0;
          cpu_act <= 1'b0;
        end
      endcase
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [AGE_W-1:0] age;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        age <= '0;
      else if (row_go && row_sel == ROW_W'(r))
        age <= '0;
      else if (age != AGE_MAX)
        age <= age + 1'b1;
    end
    assign row_stale[r] = (age == AGE_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      refresh_err <= 1'b0;
    else if (|row_stale)
      refresh_err <= 1'b1;
  end
endmodule

// File: rtl/vram_addr_mux_chk.sv
module vram_addr_mux_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  slot_ph,
  input logic [15:0] cpu_addr,
  input logic        cpu_mreq,
  input logic        cpu_rom,
  input logic [15:0] vid_addr,
  input logic [7:0]  dram_a,
  input logic        ras_n,
  input logic        cas_n,
  input logic        refresh_err
);
  p_vid_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(slot_ph) == 2'd2) |->
      (dram_a == $past(vid_addr[7:0]) && !ras_n && cas_n));

  p_vid_col_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(slot_ph) == 2'd3) |-> (!ras_n && !cas_n));

  p_cpu_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(slot_ph) == 2'd0 && $past(cpu_mreq)) |->
      (dram_a == $past(cpu_addr[7:0]) && !ras_n && cas_n));

  p_rom_nocas_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2) && $past(slot_ph) == 2'd1 &&
     $past(slot_ph, 2) == 2'd0 && $past(cpu_mreq, 2) && $past(cpu_rom, 2)) |->
      (!ras_n && cas_n));

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(slot_ph) == 2'd0 && !$past(cpu_mreq)) |-> (ras_n && cas_n));

  p_cas_needs_ras_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(refresh_err)) |-> refresh_err);
endmodule

bind vram_addr_mux vram_addr_mux_chk chk_i (
  .clk(clk), .rst_n(rst_n), .slot_ph(slot_ph), .cpu_addr(cpu_addr),
  .cpu_mreq(cpu_mreq), .cpu_rom(cpu_rom), .vid_addr(vid_addr),
  .dram_a(dram_a), .ras_n(ras_n), .cas_n(cas_n), .refresh_err(refresh_err)
);

// File: tb/vram_addr_mux_tb_top.sv
`timescale 1ns/100ps
module vram_addr_mux_tb_top;
  localparam int LIMIT = 600;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  slot_ph = 2'd0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_mreq = 1'b0;
  logic        cpu_rom = 1'b0;
  logic        cpu_rfsh = 1'b0;
  logic [15:0] vid_addr = '0;
  logic [7:0]  dram_a;
  logic        ras_n, cas_n, cpu_wait, refresh_err;
  logic        wait_seen;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2.5 clk = ~clk;

  vram_addr_mux #(.ADDR_W(16), .ROWS(128), .REFRESH_LIMIT(LIMIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .slot_ph(slot_ph), .cpu_addr(cpu_addr),
    .cpu_mreq(cpu_mreq), .cpu_rom(cpu_rom), .cpu_rfsh(cpu_rfsh),
    .vid_addr(vid_addr), .dram_a(dram_a), .ras_n(ras_n), .cas_n(cas_n),
    .cpu_wait(cpu_wait), .refresh_err(refresh_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] p);
    @(negedge clk);
    slot_ph = p;
    #1 wait_seen = cpu_wait;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cpu_mreq = 1'b0; cpu_rom = 1'b0; cpu_rfsh = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 ras_n in reset", ras_n, 1);
    check("R1 cas_n in reset", cas_n, 1);
    check("R1 dram_a in reset", dram_a, 0);
    check("R1 refresh_err in reset", refresh_err, 0);
    do_reset();
  endtask

  task automatic t_video();
    vid_addr = 16'hA53C; cpu_addr = 16'h1234; cpu_mreq = 1'b1;
    step(2'd2);
    check("R6 wait in video row", wait_seen, 1);
    check("R2 video row addr", dram_a, 8'h3C);
    check("R2 ras_n", ras_n, 0);
    check("R2 cas_n", cas_n, 1);
    vid_addr = 16'h0000;
    step(2'd3);
    check("R6 wait in video col", wait_seen, 1);
    check("R3 video col addr latched", dram_a, 8'hA5);
    check("R3 strobes", {ras_n, cas_n}, 2'b00);
    cpu_mreq = 1'b0;
  endtask

  task automatic t_cpu_ram();
    cpu_addr = 16'hBEEF; cpu_mreq = 1'b1; cpu_rom = 1'b0;
    step(2'd0);
    check("R6 no wait in cpu row", wait_seen, 0);
    check("R4 cpu row addr", dram_a, 8'hEF);
    check("R4 row strobes", {ras_n, cas_n}, 2'b01);
    cpu_addr = 16'h0000;
    step(2'd1);
    check("R6 no wait in accepted col", wait_seen, 0);
    check("R4 cpu col addr", dram_a, 8'hBE);
    check("R4 col strobes", {ras_n, cas_n}, 2'b00);
    cpu_mreq = 1'b0;
    step(2'd2); step(2'd3);
  endtask

  task automatic t_cpu_rom();
    cpu_addr = 16'h1A2B; cpu_mreq = 1'b1; cpu_rom = 1'b1;
    step(2'd0);
    check("R5 rom row addr", dram_a, 8'h2B);
    cpu_rom = 1'b0;
    step(2'd1);
    check("R5 rom col addr", dram_a, 8'h1A);
    check("R5 rom ras low cas high", {ras_n, cas_n}, 2'b01);
    cpu_mreq = 1'b0;
    step(2'd2); step(2'd3);
  endtask

  task automatic t_late_req();
    cpu_mreq = 1'b0;
    step(2'd0);
    cpu_mreq = 1'b1; cpu_addr = 16'h7777;
    step(2'd1);
    check("R6 wait for unaccepted col", wait_seen, 1);
    check("R7 no strobe for late request", {ras_n, cas_n}, 2'b11);
    cpu_mreq = 1'b0;
    step(2'd2); step(2'd3);
  endtask

  task automatic t_idle_rfsh();
    cpu_mreq = 1'b0; cpu_rfsh = 1'b1; cpu_addr = 16'h0042;
    step(2'd0);
    check("R7 R8 idle row strobes", {ras_n, cas_n}, 2'b11);
    step(2'd1);
    check("R7 R8 idle col strobes", {ras_n, cas_n}, 2'b11);
    cpu_rfsh = 1'b0;
    step(2'd2); step(2'd3);
  endtask

  task automatic t_video_sweep();
    do_reset();
    cpu_mreq = 1'b0;
    for (int k = 0; k < 640; k++) begin
      vid_addr = 16'hC000 + 16'(k % 128);
      step(2'd0); step(2'd1); step(2'd2); step(2'd3);
    end
    check("R10 video sweep keeps refresh", refresh_err, 0);
  endtask

  task automatic t_rom_sweep();
    do_reset();
    vid_addr = 16'h0000;
    for (int k = 0; k < 640; k++) begin
      cpu_addr = 16'h0080 + 16'(k % 128); cpu_mreq = 1'b1; cpu_rom = 1'b1;
      step(2'd0);
      step(2'd1);
      cpu_mreq = 1'b0;
      step(2'd2); step(2'd3);
    end
    cpu_rom = 1'b0;
    check("R9 R10 rom reads refresh by row strobe", refresh_err, 0);
  endtask

  task automatic t_starve();
    do_reset();
    vid_addr = 16'h2005; cpu_mreq = 1'b0; cpu_rfsh = 1'b1;
    for (int k = 0; k < (LIMIT - 40) / 4; k++) begin
      step(2'd0); step(2'd1); step(2'd2); step(2'd3);
    end
    check("R9 no flag before limit", refresh_err, 0);
    for (int k = 0; k < 20; k++) begin
      step(2'd0); step(2'd1); step(2'd2); step(2'd3);
    end
    check("R8 R9 flag after starvation", refresh_err, 1);
    cpu_rfsh = 1'b0;
    for (int k = 0; k < 160; k++) begin
      vid_addr = 16'(k % 128);
      step(2'd0); step(2'd1); step(2'd2); step(2'd3);
    end
    check("R9 flag sticky", refresh_err, 1);
    do_reset();
    #1 check("R1 R9 flag cleared by reset", refresh_err, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_video();
    t_cpu_ram();
    t_cpu_rom();
    t_late_req();
    t_idle_rfsh();
    t_video_sweep();
    t_rom_sweep();
    t_starve();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule